// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block is a supervisory counter clocked from a slow free-running clock. Once reset is released it counts upward. Software must service it by writing a fixed 8-bit key before the count reaches the programmed period. The period is a power of two: 2^(MIN_LOG2 + period_sel) watchdog clock cycles. With the default parameters this gives 16 to 2048 cycles, and 1024 cycles is one of the selectable settings.

Servicing is accepted only inside an open window at the late end of the period. The closed part can be none of the period, the first quarter, or the first half. If servicing is missing, comes early, or uses the wrong key, the block raises a one-cycle reset request for the system. An optional interrupt pulse warns software when three quarters of the period have elapsed. The counter keeps running after that pulse.

The configuration inputs are static. They are captured while reset is asserted and are held for the whole run.

Top module: `win_watchdog`

## Requirements
- R1: While `rst` is high, `irq_warn` and `rst_req` are low and the count is held at zero. Both outputs stay low in the first cycle after release.
- R2: Let P = 2^(MIN_LOG2 + period_sel) and call the first cycle after reset release cycle 0. With no key write, `rst_req` is high for exactly one cycle, in cycle P. The count then restarts, so the pulse repeats every P cycles.
- R3: A write of 0xAC made in cycle w inside the open window clears the count. No reset request follows, and the next overflow pulse falls in cycle w+1+P.
- R4: The `window_sel` encoding sets where the window opens. 0 gives no closed window. 1 keeps the window closed while the count is below P/4. 2 and 3 keep it closed while the count is below P/2. A write at count c is in the open window when c is at least that limit.
- R5: A write of 0xAC while the window is closed pulses `rst_req` in the next cycle and restarts the count from zero.
- R6: A write of any value other than 0xAC pulses `rst_req` in the next cycle, whatever the window state, and restarts the count.
- R7: With `irq_en` high, `irq_warn` pulses for one cycle when the count reaches 3P/4. With `irq_en` low it never pulses.
- R8: The interrupt does not stop or clear the count, and the overflow pulse still arrives in cycle P.
- R9: The interrupt fires at most once per period. It rearms after a clear, so it fires again 3P/4 cycles after each restart. A clear that lands on the cycle the interrupt would rise suppresses that interrupt.
- R10: `period_sel`, `window_sel` and `irq_en` are sampled only in the last reset cycle. Changing them while the counter runs has no effect.
- R11: A valid service in the last counted cycle (count P-1) takes priority over overflow, so no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| period_sel | input | PSEL_W | Period exponent offset: P = 2^(MIN_LOG2 + period_sel) |
| window_sel | input | 2 | Window-open fraction: 0 = 100%, 1 = 75%, 2 or 3 = 50% |
| irq_en | input | 1 | Enables the three-quarter warning interrupt |
| key_wr | input | 1 | One-cycle strobe for a write to the service register |
| key_data | input | 8 | Data value written with `key_wr` |
| irq_warn | output | 1 | One-cycle warning pulse at 3P/4 |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can fall in the same cycle.

The first pair is service and overflow. A key write can land on the final count P-1, where a valid key must win and an invalid key must give exactly one reset pulse. The bench provokes this by sweeping the write position over every count of the period, including P-1.

The second pair is clear and warning. A write at count 3P/4-1 restarts the counter on the very edge at which the warning would rise. The same sweep covers this case. The bench judges it by the presence or absence of the `irq_warn` pulse in that cycle, and by the time of the next pulse after the restart.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] SERVICE_KEY = 8'hAC;

    // Window-open fraction selector; the encoding is visible at the port.
    typedef enum logic [1:0] {
        WIN_ALL      = 2'd0,
        WIN_QTR      = 2'd1,
        WIN_HALF     = 2'd2,
        WIN_HALF_ALT = 2'd3
    } win_e;

    // Classification of one write cycle.
    typedef struct packed {
        logic service;
        logic violation;
    } key_evt_t;

    // Lowest count at which a service write is accepted.
    function automatic logic [31:0] closed_limit(input logic [31:0] per, input win_e w);
        case (w)
            WIN_ALL: return 32'd0;
            WIN_QTR: return per >> 2;
            default: return per >> 1;
        endcase
    endfunction

    // Count at which the early-warning interrupt is raised.
    function automatic logic [31:0] warn_point(input logic [31:0] per);
        return per - (per >> 2);
    endfunction

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg
    import wdg_pkg::*;
#(
    parameter int MIN_LOG2 = 4,
    parameter int PSEL_W   = 3,
    parameter int CW       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] period_sel,
    input  logic [1:0]        window_sel,
    input  logic              irq_en,
    output logic [CW-1:0]     last_cnt,
    output logic [CW-1:0]     close_lim,
    output logic [CW-1:0]     warn_cnt,
    output logic              warn_en
);

    logic [PSEL_W-1:0] sel_q;
    win_e              win_q;
    logic              en_q;
    logic [31:0]       per;

    // Capture only while reset is held: the last reset cycle wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= period_sel;
            win_q <= win_e'(window_sel);
            en_q  <= irq_en;
        end
    end

    always_comb begin
        per       = 32'd1 << (MIN_LOG2 + int'(sel_q));
        last_cnt  = CW'(per - 32'd1);
        close_lim = CW'(closed_limit(per, win_q));
        warn_cnt  = CW'(warn_point(per));
        warn_en   = en_q;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(sel_q) && $stable(win_q) && $stable(en_q))); // R10

endmodule

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
#(
    parameter logic [7:0] KEY = SERVICE_KEY
) (
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       win_open,
    output key_evt_t   evt
);

    logic key_ok;

    always_comb begin
        key_ok        = (key_data == KEY);
        evt.service   = key_wr && key_ok && win_open;
        evt.violation = key_wr && !(key_ok && win_open);
    end

endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  key_evt_t      evt,
    input  logic [CW-1:0] last_cnt,
    input  logic [CW-1:0] close_lim,
    input  logic [CW-1:0] warn_cnt,
    input  logic          warn_en,
    output logic [CW-1:0] cnt,
    output logic          win_open,
    output logic          irq,
    output logic          req
);

    logic [CW-1:0] cnt_inc;
    logic          req_nxt;
    logic          restart;

    always_comb begin
        win_open = (cnt >= close_lim);
        cnt_inc  = cnt + CW'(1);
        req_nxt  = evt.violation || ((cnt == last_cnt) && !evt.service);
        restart  = req_nxt || evt.service;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
            req <= 1'b0;
        end else begin
            req <= req_nxt;
            cnt <= restart ? '0 : cnt_inc;
            irq <= warn_en && !restart && (cnt_inc == warn_cnt);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_cnt); // R2

    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.service |=> (cnt == '0) && !req); // R3

    AST_IRQ_POINT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == warn_cnt) && warn_en); // R7

    AST_LAST_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (cnt == last_cnt) && evt.service |=> !req); // R11

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int         MIN_LOG2 = 4,
    parameter int         PSEL_W   = 3,
    parameter logic [7:0] KEY      = SERVICE_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] period_sel,
    input  logic [1:0]        window_sel,
    input  logic              irq_en,
    input  logic              key_wr,
    input  logic [7:0]        key_data,
    output logic              irq_warn,
    output logic              rst_req
);

    localparam int CW = MIN_LOG2 + (1 << PSEL_W);

    logic [CW-1:0] last_cnt;
    logic [CW-1:0] close_lim;
    logic [CW-1:0] warn_cnt;
    logic          warn_en;
    logic [CW-1:0] cnt;
    logic          win_open;
    key_evt_t      evt;

    wdg_cfg #(.MIN_LOG2(MIN_LOG2), .PSEL_W(PSEL_W), .CW(CW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .period_sel (period_sel),
        .window_sel (window_sel),
        .irq_en     (irq_en),
        .last_cnt   (last_cnt),
        .close_lim  (close_lim),
        .warn_cnt   (warn_cnt),
        .warn_en    (warn_en)
    );

    wdg_key #(.KEY(KEY)) u_key (
        .key_wr   (key_wr),
        .key_data (key_data),
        .win_open (win_open),
        .evt      (evt)
    );

    wdg_count #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .last_cnt  (last_cnt),
        .close_lim (close_lim),
        .warn_cnt  (warn_cnt),
        .warn_en   (warn_en),
        .cnt       (cnt),
        .win_open  (win_open),
        .irq       (irq_warn),
        .req       (rst_req)
    );

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
        key_wr && (key_data != KEY) |=> rst_req); // R6

    AST_CLOSED_KEY: assert property (@(posedge clk) disable iff (rst)
        key_wr && !win_open |=> rst_req); // R5

    AST_SILENT_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == last_cnt) && !key_wr |=> rst_req && (cnt == '0)); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !warn_en |-> !irq_warn); // R7

endmodule

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;

    localparam int MIN_LOG2 = 4;
    localparam int PSEL_W   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PSEL_W-1:0] period_sel = '0;
    logic [1:0]        window_sel = '0;
    logic              irq_en = 1'b0;
    logic              key_wr = 1'b0;
    logic [7:0]        key_data = '0;
    logic              irq_warn;
    logic              rst_req;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    win_watchdog #(.MIN_LOG2(MIN_LOG2), .PSEL_W(PSEL_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .period_sel (period_sel),
        .window_sel (window_sel),
        .irq_en     (irq_en),
        .key_wr     (key_wr),
        .key_data   (key_data),
        .irq_warn   (irq_warn),
        .rst_req    (rst_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wrong_key(input int w);
        case (w % 4)
            0:       return 8'h00;
            1:       return 8'hAD;
            2:       return 8'h2C;
            default: return 8'hCA;
        endcase
    endfunction

    // kind: 0 = no write, 1 = 0xAC written in cycle w, 2 = wrong value written in cycle w
    task automatic run_case(input int sel, input int win, input bit en, input int kind, input int w);
        int    p, q3, cl, len;
        bit    er, ei;
        string rtag, itag;
        p  = 1 << (MIN_LOG2 + sel);
        q3 = p - p / 4;
        cl = (win == 0) ? 0 : (win == 1) ? p / 4 : p / 2;
        len = (kind == 0) ? 2 * p : w + 1 + p;

        @(negedge clk);
        rst        = 1'b1;
        key_wr     = 1'b0;
        period_sel = PSEL_W'(sel);
        window_sel = 2'(win);
        irq_en     = en;
        repeat (2) @(negedge clk);
        check(!irq_warn && !rst_req, "R1 reset outputs", int'({irq_warn, rst_req}), 0);

        rst = 1'b0;
        // R10: scramble configuration right after release
        period_sel = ~PSEL_W'(sel);
        window_sel = ~2'(win);
        irq_en     = ~en;

        if (kind == 0)       rtag = "R2/R10 overflow";
        else if (kind == 2)  rtag = "R6 wrong key";
        else if (w < cl)     rtag = "R4/R5 closed window";
        else if (w == p - 1) rtag = "R11 last-count service";
        else                 rtag = "R3 service";
        itag = (kind == 0) ? "R7/R8 warning" : "R9 warning rearm";

        for (int t = 0; t <= len; t++) begin
            if (t > 0) @(negedge clk);
            if (kind == 0) begin
                er = (t == p) || (t == 2 * p);
                ei = en && ((t == q3) || (t == p + q3));
            end else begin
                er = ((t == w + 1) && (kind == 2 || w < cl)) || (t == w + 1 + p);
                ei = en && (((t <= w) && (t == q3)) || (t == w + 1 + q3));
            end
            if (t == 0) check(!rst_req && !irq_warn, "R1 first cycle", int'({irq_warn, rst_req}), 0);
            check(rst_req == er, rtag, int'(rst_req), int'(er));
            check(irq_warn == ei, itag, int'(irq_warn), int'(ei));
            key_wr   = (kind != 0) && (t == w);
            key_data = (kind == 1) ? 8'hAC : wrong_key(w);
        end
        key_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1-watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Idle runs: R2, R7, R8, R10, including the 2^10 setting
        for (int sel = 0; sel <= 2; sel++)
            for (int win = 0; win < 4; win++)
                for (int en = 0; en < 2; en++)
                    run_case(sel, win, 1'(en), 0, 0);
        for (int win = 0; win < 4; win++)
            for (int en = 0; en < 2; en++)
                run_case(6, win, 1'(en), 0, 0);
        // Write-position sweeps: R3, R4, R5, R6, R9, R11
        for (int sel = 0; sel <= 2; sel++) begin
            int p;
            int step;
            p    = 1 << (MIN_LOG2 + sel);
            step = (sel == 2) ? 4 : 1;
            for (int win = 0; win < 4; win++)
                for (int en = 0; en < 2; en++)
                    for (int kind = 1; kind <= 2; kind++) begin
                        for (int w = 0; w < p; w += step)
                            run_case(sel, win, 1'(en), kind, w);
                        if (step != 1) run_case(sel, win, 1'(en), kind, p - 1);
                    end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule